// File: doc/BRIEF.md
# Expansion Card Configuration Responder

This block lets a 16-bit expansion card answer the automatic configuration cycle of a 68000-style bus. Until it is configured, the card shows sixteen identity bytes in its low configuration window. Each byte is split into two nibbles, and a host reads them one after the other to learn the board type, the product, the manufacturer, the serial number and the boot ROM offset. The identity bytes are fixed when the card is built and are set by a parameter. Any byte beyond the loaded count reads as erased.

The host ends configuration in one of two ways:

- It writes a base address. The card is then mapped at that base, and from then on the block asserts a decode-hit output for accesses that fall in its 64 KiB window.
- It writes the shut-up offset. The card is then retired and never decodes.

Either write sets the configured flag. It also sends a one-clock pulse to the next card in the chain so that it can begin its own configuration.

Top module: `xcard_cfg`

## Requirements
- R1: After reset the block is unconfigured with `configured`=0, `mapped`=0, `base`=0, `chain_next`=0 and `hit`=0.
- R2: While unconfigured with `cfg_sel`=1 and `rd`=1, a read at an even offset `off`<0x40 with `off[1]`=0 returns the high nibble of identity byte `off[5:2]` in `rdata[7:4]`, and with `off[1]`=1 it returns the low nibble. Bits 3:0 are always 1.
- R3: The nibble is presented inverted at every offset except 0x00 and 0x02 (and 0x40/0x42 outside the read range), where it is presented true.
- R4: Identity byte indices at or above `LOADED`, odd offsets, offsets of 0x40 and above, reads with `cfg_sel`=0, and all reads once `configured`=1 return 0xFF.
- R5: A write with `cfg_sel`=1 to offset 0x48 while unconfigured takes effect at the next clock. It stores `wdata` in `base` and sets `configured`=1 and `mapped`=1.
- R6: A write with `cfg_sel`=1 to offset 0x4C while unconfigured takes effect at the next clock. It sets `configured`=1, leaves `mapped`=0, and leaves `base` unchanged.
- R7: The write that configures the card raises `chain_next` for exactly one clock, in the cycle after the write.
- R8: Once configured, further writes to 0x48 or 0x4C change neither `base` nor `mapped`, and they raise no `chain_next` pulse.
- R9: `hit` is 1 exactly when `mapped`=1 and `addr[23:16]` equals `base`. It is never 1 for a card that was shut up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 1 | Configuration window selected for this card |
| rd | input | 1 | Byte read strobe |
| wr | input | 1 | Byte write strobe |
| addr | input | ADDR_W | Bus byte address; the low 16 bits are the window offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the configuration window |
| configured | output | 1 | Configuration has ended |
| mapped | output | 1 | Card was given a base address |
| base | output | ADDR_W-16 | Latched base address (upper address bits) |
| chain_next | output | 1 | One-clock pulse that starts the next card's configuration |
| hit | output | 1 | Access falls inside the mapped 64 KiB window |

## Verification
The bench builds the block with a 24-bit address and an identity set whose bytes all differ, with `LOADED` set to 12. This places four erased byte slots in the read window, alongside the two true-polarity offsets and the inverted ones. Random offsets across the whole low window, including odd offsets and those of 0x40 and above, are compared with a bench model of the nibble encoding. Each run uses both ways of ending configuration, with a reset between them. This brings the shut-up path and the unchanged base within reach, as well as late writes after configuration and random decode addresses that both match and miss the latched base.

// File: rtl/xcard_cfg.sv
module xcard_cfg #(
  parameter int ADDR_W = 24,
  parameter int NUM_ID = 16,
  parameter int LOADED = 16,
  parameter logic [8*NUM_ID-1:0] IDENTITY = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              configured,
  output logic              mapped,
  output logic [ADDR_W-17:0] base,
  output logic              chain_next,
  output logic              hit
);
  localparam int IDX_W   = $clog2(NUM_ID);
  localparam int WIN_END = 4 * NUM_ID;

  logic [15:0]      off;
  logic [IDX_W-1:0] idx;
  logic [7:0]       id_byte;
  logic [3:0]       nib;
  logic             true_pol;
  logic             slot_ok;
  logic             cfg_wr;
  logic             map_wr;
  logic             quiet_wr;

  assign off      = addr[15:0];
  assign idx      = off[IDX_W+1:2];
  assign id_byte  = IDENTITY[8*idx +: 8];
  assign nib      = off[1] ? id_byte[3:0] : id_byte[7:4];
  assign true_pol = (off == 16'h0000) || (off == 16'h0002) ||
                    (off == 16'h0040) || (off == 16'h0042);
  assign slot_ok  = cfg_sel && rd && !configured && !off[0] &&
                    (int'(off) < WIN_END) && (int'(idx) < LOADED);
  assign rdata    = slot_ok ? {(true_pol ? nib : ~nib), 4'hF} : 8'hFF;

  assign cfg_wr   = cfg_sel && wr && !configured;
  assign map_wr   = cfg_wr && (off == 16'h0048);
  assign quiet_wr = cfg_wr && (off == 16'h004C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      configured <= 1'b0;
      mapped     <= 1'b0;
      base       <= '0;
      chain_next <= 1'b0;
    end else begin
      chain_next <= map_wr || quiet_wr;
      if (map_wr) begin
        base       <= wdata[ADDR_W-17:0];
        mapped     <= 1'b1;
        configured <= 1'b1;
      end else if (quiet_wr) begin
        configured <= 1'b1;
      end
    end
  end

  assign hit = mapped && (addr[ADDR_W-1:16] == base);
endmodule

module xcard_cfg_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd,
  input logic [7:0]        rdata,
  input logic              configured,
  input logic              mapped,
  input logic [ADDR_W-17:0] base,
  input logic              chain_next,
  input logic              hit
);
  // R7
  chain_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_next |=> !chain_next);
  // R7
  chain_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chain_next) |-> configured);
  // R8
  config_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    configured |=> (configured && $stable(base) && $stable(mapped)));
  // R4
  closed_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (configured && rd) |-> (rdata == 8'hFF));
  // R9
  hit_needs_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (mapped && configured));
  // R2
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[3:0] == 4'hF);
endmodule

bind xcard_cfg xcard_cfg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd), .rdata(rdata), .configured(configured),
  .mapped(mapped), .base(base), .chain_next(chain_next), .hit(hit)
);

// File: tb/xcard_cfg_bench.sv
module xcard_cfg_bench;
  localparam int ADDR_W = 24;
  localparam int NUM_ID = 16;
  localparam int LOADED = 12;
  localparam logic [8*NUM_ID-1:0] IDENT = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic configured, mapped, chain_next, hit;
  logic [7:0] base;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  xcard_cfg #(.ADDR_W(ADDR_W), .NUM_ID(NUM_ID), .LOADED(LOADED), .IDENTITY(IDENT)) u_xcard_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .configured(configured), .mapped(mapped),
    .base(base), .chain_next(chain_next), .hit(hit)
  );

  function automatic logic [7:0] exp_read(input logic [15:0] o, input logic sel, input logic cfgd);
    logic [7:0] b;
    logic [3:0] n;
    if (!sel || cfgd || o[0] || o >= 16'h0040 || (o >> 2) >= LOADED) return 8'hFF;
    b = IDENT[8*(o>>2) +: 8];
    n = o[1] ? b[3:0] : b[7:4];
    if (o == 16'h0000 || o == 16'h0002) return {n, 4'hF};
    return {~n, 4'hF};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_read(input string req, input logic [15:0] o, input logic sel);
    @(negedge clk);
    cfg_sel = sel; rd = 1'b1; wr = 1'b0; addr = {8'h00, o};
    #1;
    check(req, {24'h0, rdata}, {24'h0, exp_read(o, sel, configured)});
    rd = 1'b0; cfg_sel = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] o, input logic [7:0] d);
    @(negedge clk);
    cfg_sel = 1'b1; wr = 1'b1; addr = {8'h00, o}; wdata = d;
    @(negedge clk);
    wr = 1'b0; cfg_sel = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] o;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 configured", configured, 0);
    check("R1 mapped", mapped, 0);
    check("R1 base", base, 0);
    check("R1 chain", chain_next, 0);
    check("R1 hit", hit, 0);

    do_read("R3 true high 0x00", 16'h0000, 1'b1);
    do_read("R3 true low 0x02", 16'h0002, 1'b1);
    do_read("R2 inverted high 0x04", 16'h0004, 1'b1);
    do_read("R2 inverted low 0x06", 16'h0006, 1'b1);
    do_read("R4 unloaded byte 12", 16'h0030, 1'b1);
    do_read("R4 last slot 0x3E", 16'h003E, 1'b1);
    do_read("R4 odd offset", 16'h0005, 1'b1);
    do_read("R4 offset 0x40", 16'h0040, 1'b1);
    do_read("R4 not selected", 16'h0004, 1'b0);
    for (int k = 0; k < 200; k++) begin
      o = 16'($urandom_range(0, 16'h004F));
      do_read("R2 random read", o, 1'b1);
    end

    do_write(16'h0044, 8'h55);
    check("R6 other offset ignored", configured, 0);

    do_write(16'h004C, 8'h77);
    #1;
    check("R6 shut-up configured", configured, 1);
    check("R6 shut-up unmapped", mapped, 0);
    check("R6 base unchanged", base, 0);
    check("R7 chain pulse shut-up", chain_next, 1);
    @(negedge clk); #1;
    check("R7 chain one clock", chain_next, 0);
    addr = 24'h000010; #1;
    check("R9 no hit after shut-up", hit, 0);
    do_read("R4 closed after shut-up", 16'h0000, 1'b1);

    do_reset();
    #1;
    check("R1 reset after shut-up", configured, 0);
    do_write(16'h0048, 8'hA3);
    #1;
    check("R5 configured", configured, 1);
    check("R5 mapped", mapped, 1);
    check("R5 base", base, 8'hA3);
    check("R7 chain pulse map", chain_next, 1);
    @(negedge clk); #1;
    check("R7 chain one clock map", chain_next, 0);

    do_write(16'h0048, 8'h11);
    #1;
    check("R8 base kept", base, 8'hA3);
    check("R8 no chain", chain_next, 0);
    do_write(16'h004C, 8'h22);
    #1;
    check("R8 mapped kept", mapped, 1);
    check("R8 no chain shut-up", chain_next, 0);
    do_read("R4 closed after map", 16'h0004, 1'b1);

    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (k % 3 == 0) addr = {8'hA3, 16'($urandom)};
      else addr = 24'($urandom);
      #1;
      check("R9 decode hit", hit, addr[23:16] == 8'hA3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule